// File: doc/BRIEF.md
# Lane SKP Ordered Set Builder and Parser

This block handles the clock-compensation ordered set of a 128b/130b lane, one 8-bit symbol per clock. Its transmit half produces a fixed-length skip block when the lane's sender asks for one. The block is marked with an ordered-set sync header. Twelve skip symbols come first, then an end marker and three trailer bytes. A mode input picks what the trailer carries. In compliance mode it carries an error count and its inverse. In normal mode it carries the scrambler state, and its topmost bit is either a data-stream parity bit or the inverse of the highest scrambler bit.

The receive half parses a skip block whose length may have been changed by elastic buffers along the path. Skip symbols may be added or removed in groups of four. It counts the skip symbols in front of the end marker, checks that the count is legal, and collects the three trailer bytes. It then reports the count and the trailer in a one-cycle result, and the clock-compensation logic upstream uses these to trim or pad. Both halves raise a hold output while a skip block is in flight, so that the lane scrambler does not advance over these symbols.

Top module: `skp_os_unit`

## Requirements
- R1: After reset, `tx_valid`, `tx_first`, `tx_last`, `tx_scr_hold`, `rx_done`, `rx_err` and `rx_scr_hold` are 0, and `tx_sym` and `tx_sync` are 0.
- R2: A `tx_start` pulse while idle produces exactly 16 contiguous symbols, starting one cycle later. `tx_first` is high with `tx_sync` = 2'b01 on symbol 0 only, and `tx_last` is high on symbol 15 only.
- R3: Transmit symbols 0 to 11 are 8'hAA and symbol 12 is the end marker 8'hE1.
- R4: In compliance mode the transmit symbols 13, 14 and 15 are 8'hAA, then the error count, then its bitwise inverse.
- R5: In normal mode symbol 13 is {top, lfsr[22:16]}, symbol 14 is lfsr[15:8] and symbol 15 is lfsr[7:0]. Here top is `tx_data_parity` when `tx_after_data` is 1, and ~lfsr[22] otherwise.
- R6: The mode and trailer inputs are captured on the accepted `tx_start`. A `tx_start` during a block has no effect: the block keeps its content and length, and no second block follows.
- R7: `tx_scr_hold` is high on every transmitted symbol. `rx_scr_hold` is high from the receive start symbol until the result cycle.
- R8: The receiver accepts 8, 12, 16, 20 or 24 leading 8'hAA symbols, followed by 8'hE1 and three trailer bytes. One cycle after the last trailer byte it pulses `rx_done` with `rx_err` = 0, `rx_skp_count` set to the number of 8'hAA symbols, and `rx_trailer` = {byte1, byte2, byte3} with byte1 in bits 23:16.
- R9: The receiver pulses `rx_done` with `rx_err` = 1 one cycle after an 8'hE1 that follows a skip count not in {8,12,16,20,24}.
- R10: The receiver pulses `rx_done` with `rx_err` = 1 one cycle after any symbol before the end marker that is neither 8'hAA nor 8'hE1, and one cycle after a 25th 8'hAA.
- R11: With `rx_compliance` = 1, a third trailer byte that is not the inverse of the second one gives `rx_err` = 1. A matching pair gives `rx_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_start | input | 1 | Request one transmit skip block |
| tx_compliance | input | 1 | 1: error-count trailer, 0: scrambler trailer |
| tx_err_cnt | input | 8 | Error count for the compliance trailer |
| tx_lfsr | input | 23 | Current scrambler state |
| tx_after_data | input | 1 | Block follows a data stream |
| tx_data_parity | input | 1 | Data-stream parity bit |
| tx_valid | output | 1 | Transmit symbol valid |
| tx_first | output | 1 | Symbol 0 of the block |
| tx_last | output | 1 | Final symbol of the block |
| tx_sym | output | 8 | Transmit symbol |
| tx_sync | output | 2 | Sync header, meaningful with tx_first |
| tx_scr_hold | output | 1 | Freeze the transmit scrambler |
| rx_valid | input | 1 | Receive symbol valid |
| rx_start | input | 1 | Receive symbol is symbol 0 of a skip block |
| rx_sym | input | 8 | Receive symbol |
| rx_compliance | input | 1 | Check the error-count pair |
| rx_done | output | 1 | One-cycle result strobe |
| rx_err | output | 1 | Result is a malformed block |
| rx_skp_count | output | 5 | Number of skip symbols seen |
| rx_trailer | output | 24 | Three trailer bytes |
| rx_scr_hold | output | 1 | Freeze the receive scrambler |

## Verification
The assertions check on every cycle the shape of the transmit stream. They check that symbol 0 is a skip symbol with the ordered-set header, that a block never breaks off before its last symbol, that the scrambler hold covers every transmitted symbol, that the result strobe lasts one cycle, and that a good result always carries a legal skip count. The symbol values themselves can only be shown by the bench's scenarios. These cover the trailer contents under each mode and parity choice, a start request during a block being ignored, each legal received length, misplaced end markers, foreign symbols, an overlong run, and compliance pairs that match and that do not.

// File: rtl/skp_pkg.sv
package skp_pkg;
    localparam int SYM_W     = 8;
    localparam int LFSR_W    = 23;
    localparam int TX_SKIPS  = 12;
    localparam int TRAIL_N   = 3;
    localparam int TX_LEN    = TX_SKIPS + 1 + TRAIL_N;
    localparam int RX_MIN    = 8;
    localparam int RX_MAX    = 24;
    localparam int GRP       = 4;
    localparam int IDX_W     = $clog2(TX_LEN);
    localparam int CNT_W     = $clog2(RX_MAX + 1);
    localparam int TRL_W     = TRAIL_N * SYM_W;

    localparam logic [SYM_W-1:0] SKIP_CODE = 8'hAA;
    localparam logic [SYM_W-1:0] END_CODE  = 8'hE1;
    localparam logic [1:0]       OS_HDR    = 2'b01;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_SKIP,
        RX_TAIL
    } rx_state_t;

    typedef struct packed {
        logic              comp;
        logic [SYM_W-1:0]  err;
        logic [LFSR_W-1:0] lfsr;
        logic              top;
    } tx_fields_t;

    function automatic logic count_legal(input logic [CNT_W-1:0] n);
        int unsigned v;
        v = int'(n);
        return (v >= RX_MIN) && (v <= RX_MAX) && ((v % GRP) == 0);
    endfunction
endpackage

// File: rtl/skp_tx_gen.sv
module skp_tx_gen
    import skp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              comp,
    input  logic [SYM_W-1:0]  err_cnt,
    input  logic [LFSR_W-1:0] lfsr,
    input  logic              after_data,
    input  logic              data_par,
    output logic              valid,
    output logic              first,
    output logic              last,
    output logic [SYM_W-1:0]  sym,
    output logic [1:0]        sync,
    output logic              hold
);
    logic             busy;
    logic [IDX_W-1:0] idx;
    tx_fields_t       fld;

    localparam logic [IDX_W-1:0] END_IDX  = IDX_W'(TX_SKIPS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TX_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            idx  <= '0;
            fld  <= '0;
        end else if (!busy) begin
            if (start) begin
                busy     <= 1'b1;
                idx      <= '0;
                fld.comp <= comp;
                fld.err  <= err_cnt;
                fld.lfsr <= lfsr;
                fld.top  <= after_data ? data_par : ~lfsr[LFSR_W-1];
            end
        end else begin
            if (idx == LAST_IDX) begin
                busy <= 1'b0;
                idx  <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

    always_comb begin
        sym = '0;
        if (busy) begin
            if (idx < END_IDX)
                sym = SKIP_CODE;
            else if (idx == END_IDX)
                sym = END_CODE;
            else if (idx == END_IDX + 1'b1)
                sym = fld.comp ? SKIP_CODE : {fld.top, fld.lfsr[LFSR_W-1:2*SYM_W]};
            else if (idx == END_IDX + 2'd2)
                sym = fld.comp ? fld.err : fld.lfsr[2*SYM_W-1:SYM_W];
            else
                sym = fld.comp ? ~fld.err : fld.lfsr[SYM_W-1:0];
        end
    end

    assign valid = busy;
    assign first = busy && (idx == '0);
    assign last  = busy && (idx == LAST_IDX);
    assign sync  = (busy && (idx == '0)) ? OS_HDR : 2'b00;
    assign hold  = busy;
endmodule

// File: rtl/skp_rx_chk.sv
module skp_rx_chk
    import skp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             start,
    input  logic [SYM_W-1:0] sym,
    input  logic             comp,
    output logic             done,
    output logic             err,
    output logic [CNT_W-1:0] count,
    output logic [TRL_W-1:0] trailer,
    output logic             hold
);
    rx_state_t        state;
    logic [CNT_W-1:0] cnt;
    logic [1:0]       tidx;
    logic [TRL_W-1:0] tbuf;
    logic [TRL_W-1:0] tnext;

    localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(RX_MAX);
    localparam logic [1:0]       TAIL_TOP = 2'(TRAIL_N - 1);

    assign tnext = {tbuf[TRL_W-SYM_W-1:0], sym};

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            cnt     <= '0;
            tidx    <= '0;
            tbuf    <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
            count   <= '0;
            trailer <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (valid && start) begin
                        if (sym == SKIP_CODE) begin
                            cnt   <= CNT_W'(1);
                            state <= RX_SKIP;
                        end else begin
                            done  <= 1'b1;
                            err   <= 1'b1;
                            count <= '0;
                        end
                    end
                end
                RX_SKIP: begin
                    if (valid) begin
                        if (sym == SKIP_CODE && cnt != CNT_TOP) begin
                            cnt <= cnt + 1'b1;
                        end else if (sym == END_CODE && count_legal(cnt)) begin
                            tidx  <= '0;
                            state <= RX_TAIL;
                        end else begin
                            done  <= 1'b1;
                            err   <= 1'b1;
                            count <= cnt;
                            state <= RX_IDLE;
                        end
                    end
                end
                RX_TAIL: begin
                    if (valid) begin
                        tbuf <= tnext;
                        tidx <= tidx + 1'b1;
                        if (tidx == TAIL_TOP) begin
                            done    <= 1'b1;
                            err     <= comp && (sym != ~tbuf[SYM_W-1:0]);
                            count   <= cnt;
                            trailer <= tnext;
                            state   <= RX_IDLE;
                        end
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end

    assign hold = (state != RX_IDLE) || (valid && start);
endmodule

// File: rtl/skp_os_unit.sv
module skp_os_unit
    import skp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_start,
    input  logic              tx_compliance,
    input  logic [SYM_W-1:0]  tx_err_cnt,
    input  logic [LFSR_W-1:0] tx_lfsr,
    input  logic              tx_after_data,
    input  logic              tx_data_parity,
    output logic              tx_valid,
    output logic              tx_first,
    output logic              tx_last,
    output logic [SYM_W-1:0]  tx_sym,
    output logic [1:0]        tx_sync,
    output logic              tx_scr_hold,
    input  logic              rx_valid,
    input  logic              rx_start,
    input  logic [SYM_W-1:0]  rx_sym,
    input  logic              rx_compliance,
    output logic              rx_done,
    output logic              rx_err,
    output logic [CNT_W-1:0]  rx_skp_count,
    output logic [TRL_W-1:0]  rx_trailer,
    output logic              rx_scr_hold
);
    skp_tx_gen tx_i (
        .clk        (clk),
        .rst        (rst),
        .start      (tx_start),
        .comp       (tx_compliance),
        .err_cnt    (tx_err_cnt),
        .lfsr       (tx_lfsr),
        .after_data (tx_after_data),
        .data_par   (tx_data_parity),
        .valid      (tx_valid),
        .first      (tx_first),
        .last       (tx_last),
        .sym        (tx_sym),
        .sync       (tx_sync),
        .hold       (tx_scr_hold)
    );

    skp_rx_chk rx_i (
        .clk     (clk),
        .rst     (rst),
        .valid   (rx_valid),
        .start   (rx_start),
        .sym     (rx_sym),
        .comp    (rx_compliance),
        .done    (rx_done),
        .err     (rx_err),
        .count   (rx_skp_count),
        .trailer (rx_trailer),
        .hold    (rx_scr_hold)
    );
endmodule

// File: rtl/skp_os_unit_chk.sv
module skp_os_unit_chk
    import skp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tx_valid,
    input logic             tx_first,
    input logic             tx_last,
    input logic [SYM_W-1:0] tx_sym,
    input logic [1:0]       tx_sync,
    input logic             tx_scr_hold,
    input logic             rx_done,
    input logic             rx_err,
    input logic [CNT_W-1:0] rx_skp_count
);
    // R2
    tx_head_chk: assert property (@(posedge clk) disable iff (rst)
        tx_first |-> (tx_sync == OS_HDR) && (tx_sym == SKIP_CODE) && tx_valid);

    // R2
    tx_contig_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_last) |=> tx_valid);

    // R7
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> tx_scr_hold);

    // R8
    rx_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> !rx_done);

    // R8
    rx_len_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !rx_err) |-> count_legal(rx_skp_count));
endmodule

bind skp_os_unit skp_os_unit_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .tx_valid     (tx_valid),
    .tx_first     (tx_first),
    .tx_last      (tx_last),
    .tx_sym       (tx_sym),
    .tx_sync      (tx_sync),
    .tx_scr_hold  (tx_scr_hold),
    .rx_done      (rx_done),
    .rx_err       (rx_err),
    .rx_skp_count (rx_skp_count)
);

// File: tb/skp_os_unit_tb_top.sv
module skp_os_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_start = 0, tx_compliance = 0, tx_after_data = 0, tx_data_parity = 0;
    logic [7:0]  tx_err_cnt = 0;
    logic [22:0] tx_lfsr = 0;
    logic        tx_valid, tx_first, tx_last, tx_scr_hold;
    logic [7:0]  tx_sym;
    logic [1:0]  tx_sync;
    logic        rx_valid = 0, rx_start = 0, rx_compliance = 0;
    logic [7:0]  rx_sym = 0;
    logic        rx_done, rx_err, rx_scr_hold;
    logic [4:0]  rx_skp_count;
    logic [23:0] rx_trailer;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    skp_os_unit dut_i (.*);

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        chk(tx_valid == 0 && tx_first == 0 && tx_last == 0 && tx_scr_hold == 0, "R1 tx ctl",
            {28'd0, tx_valid, tx_first, tx_last, tx_scr_hold}, 0);
        chk(tx_sym == 0 && tx_sync == 0, "R1 tx data", {22'd0, tx_sync, tx_sym}, 0);
        chk(rx_done == 0 && rx_err == 0 && rx_scr_hold == 0, "R1 rx ctl",
            {29'd0, rx_done, rx_err, rx_scr_hold}, 0);
    endtask

    task automatic t_tx(input logic comp, input logic [7:0] ec, input logic [22:0] lf,
                        input logic ad, input logic par, input logic poke);
        logic [7:0] exp;
        logic       top;
        top = ad ? par : ~lf[22];
        tx_compliance = comp; tx_err_cnt = ec; tx_lfsr = lf;
        tx_after_data = ad; tx_data_parity = par; tx_start = 1;
        @(negedge clk);
        tx_start = 0;
        for (int i = 0; i < 16; i++) begin
            if (i < 12)       exp = 8'hAA;
            else if (i == 12) exp = 8'hE1;
            else if (i == 13) exp = comp ? 8'hAA : {top, lf[22:16]};
            else if (i == 14) exp = comp ? ec : lf[15:8];
            else              exp = comp ? ~ec : lf[7:0];
            chk(tx_valid == 1, "R2 valid", {31'd0, tx_valid}, 1);
            chk(tx_first == (i == 0) && tx_last == (i == 15), "R2 marks",
                {30'd0, tx_first, tx_last}, {30'd0, i == 0, i == 15});
            if (i == 0) chk(tx_sync == 2'b01, "R2 sync", {30'd0, tx_sync}, 1);
            chk(tx_scr_hold == 1, "R7 tx hold", {31'd0, tx_scr_hold}, 1);
            chk(tx_sym == exp, i < 13 ? "R3 sym" : (comp ? "R4 trailer" : "R5 trailer"),
                {24'd0, tx_sym}, {24'd0, exp});
            if (poke && i == 5) begin
                tx_start = 1; tx_compliance = ~comp; tx_err_cnt = ~ec; tx_lfsr = ~lf;
            end
            if (i == 6) tx_start = 0;
            @(negedge clk);
        end
        chk(tx_valid == 0 && tx_scr_hold == 0, "R6 no second block",
            {30'd0, tx_valid, tx_scr_hold}, 0);
        @(negedge clk);
        chk(tx_valid == 0, "R6 still idle", {31'd0, tx_valid}, 0);
    endtask

    task automatic put(input logic [7:0] s, input logic st);
        rx_valid = 1; rx_sym = s; rx_start = st;
        @(negedge clk);
        rx_start = 0;
    endtask

    task automatic t_rx_good(input int n, input logic [23:0] tr, input logic comp, input logic exp_err,
                             input string req);
        rx_compliance = comp;
        for (int i = 0; i < n; i++) begin
            put(8'hAA, i == 0);
            if (i == 0) chk(rx_scr_hold == 1, "R7 rx hold", {31'd0, rx_scr_hold}, 1);
            else chk(rx_done == 0, req, {31'd0, rx_done}, 0);
        end
        put(8'hE1, 0);
        chk(rx_done == 0, req, {31'd0, rx_done}, 0);
        put(tr[23:16], 0);
        put(tr[15:8], 0);
        chk(rx_scr_hold == 1, "R7 rx hold tail", {31'd0, rx_scr_hold}, 1);
        put(tr[7:0], 0);
        rx_valid = 0;
        chk(rx_done == 1 && rx_err == exp_err, req, {30'd0, rx_done, rx_err}, {30'd0, 1'b1, exp_err});
        if (!exp_err) begin
            chk(rx_skp_count == 5'(n), req, {27'd0, rx_skp_count}, n);
            chk(rx_trailer == tr, req, {8'd0, rx_trailer}, {8'd0, tr});
        end
        @(negedge clk);
        chk(rx_done == 0 && rx_scr_hold == 0, "R8 one pulse", {30'd0, rx_done, rx_scr_hold}, 0);
    endtask

    task automatic t_rx_bad(input int n, input logic [7:0] term, input string req);
        rx_compliance = 0;
        for (int i = 0; i < n; i++) put(8'hAA, i == 0);
        put(term, n == 0);
        rx_valid = 0;
        chk(rx_done == 1 && rx_err == 1, req, {30'd0, rx_done, rx_err}, 3);
        @(negedge clk);
        @(negedge clk);
        chk(rx_done == 0, req, {31'd0, rx_done}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 0;
        @(negedge clk);
        t_tx(1'b0, 8'h00, 23'h5A_3C_81, 1'b0, 1'b0, 1'b0);
        t_tx(1'b0, 8'h00, 23'h2B_CD_EF, 1'b1, 1'b1, 1'b0);
        t_tx(1'b0, 8'h00, 23'h7F_00_FF, 1'b1, 1'b0, 1'b0);
        t_tx(1'b1, 8'h3C, 23'h12_34_56, 1'b0, 1'b0, 1'b0);
        t_tx(1'b1, 8'h07, 23'h40_00_01, 1'b0, 1'b1, 1'b1);
        for (int k = 2; k <= 6; k++)
            t_rx_good(4 * k, {8'(k), 8'h5E, 8'hC3}, 1'b0, 1'b0, "R8 legal length");
        t_rx_good(12, 24'hAA_3C_C3, 1'b1, 1'b0, "R11 pair match");
        t_rx_good(16, 24'hAA_3C_C2, 1'b1, 1'b1, "R11 pair mismatch");
        t_rx_bad(4, 8'hE1, "R9 end at 4");
        t_rx_bad(10, 8'hE1, "R9 end at 10");
        t_rx_bad(0, 8'hE1, "R9 end at 0");
        t_rx_bad(7, 8'h1E, "R10 foreign symbol");
        t_rx_bad(24, 8'hAA, "R10 overlong run");
        t_rx_good(20, 24'h01_02_03, 1'b0, 1'b0, "R10 recovers after error");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule